// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block drives the row strobe, the two column-byte strobes and the write strobe of an asynchronous DRAM whenever the memory needs housekeeping rather than a data access. Out of reset it owns the strobes. It keeps them idle through the power-up pause, then runs a burst of warm-up refresh cycles. In every refresh cycle the column strobe falls before the row strobe, so the device picks the row from its own counter and the sequencer never produces a row address.

After start-up an interval timer adds one owed refresh each period. The sequencer asks the access controller for the pins with a request/grant handshake. It can postpone up to a set number of refreshes. When that backlog is full it takes the pins at the next idle point without waiting for a grant. A sleep request moves the memory into self-refresh. The sequencer runs one refresh immediately before entry and one immediately after exit, holds the row strobe low for at least the minimum self-refresh time, and uses the longer self-refresh precharge on the way out. While `seqOwn` is high, an outside mux routes this block's strobes to the pins.

Top module: `dramRefreshSeq`

## Requirements
- R1: Out of reset `seqOwn` is high and every strobe is inactive (high) for exactly INIT_PAUSE cycles. WARM_CYCLES refresh cycles follow. `initDone` then rises and never falls again. `refReq` stays low until `initDone` is high.
- R2: After initialization the interval timer adds one owed refresh every REF_INTERVAL cycles. With `ctlGnt` held high, consecutive row-strobe falls are therefore exactly REF_INTERVAL cycles apart.
- R3: A refresh cycle holds the column strobes low for T_CSR cycles with the row strobe high. It then holds the row strobe low for exactly T_RASW cycles, with the column strobes still low, and releases both together.
- R4: `weN` is high in every cycle in which `seqOwn` is high.
- R5: `casN` bit 0 is the lower-byte strobe and bit 1 the upper-byte strobe. When a column strobe is low, the lanes selected by CAS_LANES are low and the others are high. With the default of 2'b11, `casN` is 2'b00 for the whole time the row strobe is low, and `sleepAck` is high only while the row strobe is low.
- R6: In self-refresh the row strobe stays low for at least SELF_MIN cycles, even if `sleepReq` drops earlier. When `sleepReq` drops right at `sleepAck`, the low time is exactly SELF_MIN. After exit the strobes stay high for T_RPS cycles before the next refresh begins, so the row strobe stays high for exactly T_RPS+T_CSR cycles.
- R7: Self-refresh sits inside one bus ownership, bracketed by two ordinary refresh cycles. That ownership contains exactly three row-strobe pulses, and the row strobe stays high for exactly T_RP+T_CSR cycles between the first refresh and self-refresh entry.
- R8: The count of owed refreshes saturates at PEND_MAX. While `ctlGnt` and `ctlIdle` are both low, no refresh starts. When the backlog is full and `ctlIdle` is high, one refresh starts without a grant. Draining a full backlog gives PEND_MAX refreshes, plus any that fall due meanwhile.
- R9: Before `seqOwn` falls, the row and column strobes have been high for at least T_RP cycles.
- R10: `refReq` is high while the sequencer is idle with a refresh owed or `sleepReq` high. The pins are taken only from idle, on `ctlGnt`, or on `ctlIdle` when the backlog is full. No refresh is lost while grants arrive in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlGnt | input | 1 | Access controller hands over the strobes |
| ctlIdle | input | 1 | Access controller has no access in flight |
| sleepReq | input | 1 | Request to enter and stay in self-refresh |
| refReq | output | 1 | Sequencer wants the strobes |
| seqOwn | output | 1 | Sequencer drives the strobes; mux select |
| initDone | output | 1 | Power-up sequence complete |
| sleepAck | output | 1 | Device is in self-refresh |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 2 | Column strobes, bit 1 upper byte, active low |
| weN | output | 1 | Write strobe, active low |

## Verification
The bench measures the exact length of the power-up pause and counts the warm-up cycles. A design that counted the pause one short, or released the pins after seven cycles, would fail there. It holds off grants long enough to overfill the backlog and then counts the refreshes in the drain. A counter that does not saturate drains too many, and one that loses the tick arriving alongside a decrement drains too few. The self-refresh cases release `sleepReq` immediately and late, and measure every row-strobe pulse and gap inside the ownership. An exit that skips the long precharge or the trailing refresh, or a hold that ends on `sleepReq` alone, shows up as a wrong pulse count or width. A random grant phase checks that no owed refresh goes missing.

// File: rtl/dramSeqPkg.sv
package dramSeqPkg;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_CSR, ST_RASLO, ST_PRE, ST_SR_CSR, ST_SR_HOLD, ST_SR_PRE
  } seqState_t;

  typedef enum logic [1:0] {
    K_WARM, K_NORMAL, K_PRESR, K_POSTSR
  } refKind_t;

  typedef enum logic [2:0] {
    PH_PAUSE, PH_CSR, PH_RASW, PH_RP, PH_RPS, PH_SELF
  } phaseSel_t;

  typedef struct packed {
    logic      phaseLoad;
    phaseSel_t phaseSel;
    logic      pendDec;
    logic      pendClr;
    logic      warmInc;
    logic      intRun;
    logic      intRestart;
  } seqStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramSeqDatapath.sv
module dramSeqDatapath
  import dramSeqPkg::*;
#(
  parameter int INIT_PAUSE   = 25000,
  parameter int T_CSR        = 1,
  parameter int T_RASW       = 8,
  parameter int T_RP         = 5,
  parameter int T_RPS        = 15,
  parameter int SELF_MIN     = 12500,
  parameter int REF_INTERVAL = 1950,
  parameter int WARM_CYCLES  = 8,
  parameter int PEND_MAX     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       phaseDone,
  output logic       pendAny,
  output logic       pendFull,
  output logic       warmLast
);

  localparam int PH_MAX = maxOf(maxOf(maxOf(INIT_PAUSE, SELF_MIN), maxOf(T_RPS, T_RP)),
                                maxOf(T_RASW, T_CSR));
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int INT_W  = $clog2(REF_INTERVAL + 1);
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam int WARM_W = $clog2(WARM_CYCLES + 1);

  logic [PH_W-1:0]   phaseCnt, phaseLoadVal;
  logic [INT_W-1:0]  intCnt;
  logic [PEND_W-1:0] pendCnt;
  logic [WARM_W-1:0] warmCnt;
  logic              tick, pendInc;

  // Phase timer: a state that loads N lasts N cycles.
  always_comb begin
    case (strobe.phaseSel)
      PH_PAUSE: phaseLoadVal = PH_W'(INIT_PAUSE - 1);
      PH_CSR:   phaseLoadVal = PH_W'(T_CSR - 1);
      PH_RASW:  phaseLoadVal = PH_W'(T_RASW - 1);
      PH_RP:    phaseLoadVal = PH_W'(T_RP - 1);
      PH_RPS:   phaseLoadVal = PH_W'(T_RPS - 1);
      default:  phaseLoadVal = PH_W'(SELF_MIN - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= PH_W'(INIT_PAUSE - 1);
    else if (strobe.phaseLoad) phaseCnt <= phaseLoadVal;
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - 1'b1;
  end
  assign phaseDone = (phaseCnt == '0);

  // Refresh interval timer.
  assign tick = strobe.intRun && !strobe.intRestart && (intCnt == INT_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  intCnt <= '0;
    else if (strobe.intRestart) intCnt <= '0;
    else if (strobe.intRun)     intCnt <= tick ? '0 : intCnt + 1'b1;
  end

  // Owed-refresh backlog, saturating; a tick alongside a decrement is never lost.
  assign pendInc = tick && (!pendFull || strobe.pendDec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              pendCnt <= '0;
    else if (strobe.pendClr)                pendCnt <= '0;
    else if (pendInc && !strobe.pendDec)    pendCnt <= pendCnt + 1'b1;
    else if (!pendInc && strobe.pendDec && pendAny) pendCnt <= pendCnt - 1'b1;
  end
  assign pendAny  = (pendCnt != '0);
  assign pendFull = (pendCnt == PEND_W'(PEND_MAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warmCnt <= '0;
    else if (strobe.warmInc) warmCnt <= warmCnt + 1'b1;
  end
  assign warmLast = (warmCnt == WARM_W'(WARM_CYCLES - 1));

  assert_pend_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_W'(PEND_MAX));

  assert_tick_adds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.pendDec && !strobe.pendClr && !pendFull)
      |=> (pendCnt == $past(pendCnt) + 1'b1));

endmodule

// File: rtl/dramSeqCtrl.sv
module dramSeqCtrl
  import dramSeqPkg::*;
#(
  parameter logic [1:0] CAS_LANES = 2'b11,
  parameter int         T_RP      = 5,
  parameter int         SELF_MIN  = 12500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlGnt,
  input  logic       ctlIdle,
  input  logic       sleepReq,
  input  logic       phaseDone,
  input  logic       pendAny,
  input  logic       pendFull,
  input  logic       warmLast,
  output seqStrobe_t strobe,
  output logic       refReq,
  output logic       seqOwn,
  output logic       initDone,
  output logic       sleepAck,
  output logic       rasN,
  output logic [1:0] casN,
  output logic       weN
);

  localparam int LOW_W = $clog2(SELF_MIN + 1);
  localparam int HI_W  = $clog2(T_RP + 1);

  seqState_t st, stNext;
  refKind_t  kind, kindNext;
  logic      inSr, grab, casLow;

  assign inSr = (st inside {ST_SR_CSR, ST_SR_HOLD, ST_SR_PRE}) ||
                (kind == K_POSTSR && st != ST_IDLE);
  assign grab = ctlGnt || (pendFull && ctlIdle);

  always_comb begin
    stNext            = st;
    kindNext          = kind;
    strobe            = '0;
    strobe.phaseSel   = PH_CSR;
    strobe.intRun     = initDone && !inSr;
    strobe.intRestart = inSr;
    case (st)
      ST_PAUSE: if (phaseDone) begin
        stNext = ST_CSR; kindNext = K_WARM; strobe.phaseLoad = 1'b1;
      end
      ST_IDLE: begin
        if (ctlGnt && sleepReq) begin
          stNext = ST_CSR; kindNext = K_PRESR; strobe.phaseLoad = 1'b1;
        end else if (pendAny && grab) begin
          stNext = ST_CSR; kindNext = K_NORMAL; strobe.phaseLoad = 1'b1;
        end
      end
      ST_CSR: if (phaseDone) begin
        stNext = ST_RASLO; strobe.phaseLoad = 1'b1; strobe.phaseSel = PH_RASW;
      end
      ST_RASLO: if (phaseDone) begin
        stNext = ST_PRE; strobe.phaseLoad = 1'b1; strobe.phaseSel = PH_RP;
      end
      ST_PRE: if (phaseDone) begin
        case (kind)
          K_WARM: begin
            strobe.warmInc = 1'b1;
            if (warmLast) stNext = ST_IDLE;
            else begin stNext = ST_CSR; strobe.phaseLoad = 1'b1; end
          end
          K_NORMAL: begin strobe.pendDec = 1'b1; stNext = ST_IDLE; end
          K_PRESR:  begin stNext = ST_SR_CSR; strobe.phaseLoad = 1'b1; end
          default:  stNext = ST_IDLE;
        endcase
      end
      ST_SR_CSR: if (phaseDone) begin
        stNext = ST_SR_HOLD; strobe.phaseLoad = 1'b1; strobe.phaseSel = PH_SELF;
        strobe.pendClr = 1'b1;
      end
      ST_SR_HOLD: if (phaseDone && !sleepReq) begin
        stNext = ST_SR_PRE; strobe.phaseLoad = 1'b1; strobe.phaseSel = PH_RPS;
      end
      ST_SR_PRE: if (phaseDone) begin
        stNext = ST_CSR; kindNext = K_POSTSR; strobe.phaseLoad = 1'b1;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_PAUSE;
      kind     <= K_WARM;
      initDone <= 1'b0;
    end else begin
      st   <= stNext;
      kind <= kindNext;
      if (strobe.warmInc && warmLast) initDone <= 1'b1;
    end
  end

  assign casLow   = st inside {ST_CSR, ST_RASLO, ST_SR_CSR, ST_SR_HOLD};
  assign rasN     = !(st inside {ST_RASLO, ST_SR_HOLD});
  assign casN     = casLow ? ~CAS_LANES : 2'b11;
  assign weN      = 1'b1;
  assign seqOwn   = (st != ST_IDLE);
  assign sleepAck = (st == ST_SR_HOLD);
  assign refReq   = (st == ST_IDLE) && (pendAny || sleepReq);

  // Run-length counters for the timing checks below.
  logic [LOW_W-1:0] lowRun;
  logic [HI_W-1:0]  hiRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
      hiRun  <= '0;
    end else begin
      if (rasN)                            lowRun <= '0;
      else if (lowRun != LOW_W'(SELF_MIN)) lowRun <= lowRun + 1'b1;
      if (!(seqOwn && rasN && casN == 2'b11)) hiRun <= '0;
      else if (hiRun != HI_W'(T_RP))          hiRun <= hiRun + 1'b1;
    end
  end

  assert_cbr_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (casN != 2'b11) && ($past(casN) != 2'b11));

  assert_init_sticky_R1: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  assert_init_owns_R1: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (seqOwn && !refReq));

  assert_self_min_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rasN) && $past(sleepAck)) |-> (lowRun == LOW_W'(SELF_MIN)));

  assert_ack_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    sleepAck |-> (!rasN && casN != 2'b11));

  assert_release_precharged_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqOwn) |-> (hiRun == HI_W'(T_RP)));

endmodule

// File: rtl/dramRefreshSeq.sv
module dramRefreshSeq
  import dramSeqPkg::*;
#(
  parameter int         INIT_PAUSE   = 25000,
  parameter int         T_CSR        = 1,
  parameter int         T_RASW       = 8,
  parameter int         T_RP         = 5,
  parameter int         T_RPS        = 15,
  parameter int         SELF_MIN     = 12500,
  parameter int         REF_INTERVAL = 1950,
  parameter int         WARM_CYCLES  = 8,
  parameter int         PEND_MAX     = 8,
  parameter logic [1:0] CAS_LANES    = 2'b11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlGnt,
  input  logic       ctlIdle,
  input  logic       sleepReq,
  output logic       refReq,
  output logic       seqOwn,
  output logic       initDone,
  output logic       sleepAck,
  output logic       rasN,
  output logic [1:0] casN,
  output logic       weN
);

  seqStrobe_t strobe;
  logic       phaseDone, pendAny, pendFull, warmLast;

  dramSeqCtrl #(
    .CAS_LANES(CAS_LANES), .T_RP(T_RP), .SELF_MIN(SELF_MIN)
  ) ctrl (
    .clk(clk), .rstN(rstN), .ctlGnt(ctlGnt), .ctlIdle(ctlIdle), .sleepReq(sleepReq),
    .phaseDone(phaseDone), .pendAny(pendAny), .pendFull(pendFull), .warmLast(warmLast),
    .strobe(strobe), .refReq(refReq), .seqOwn(seqOwn), .initDone(initDone),
    .sleepAck(sleepAck), .rasN(rasN), .casN(casN), .weN(weN)
  );

  dramSeqDatapath #(
    .INIT_PAUSE(INIT_PAUSE), .T_CSR(T_CSR), .T_RASW(T_RASW), .T_RP(T_RP), .T_RPS(T_RPS),
    .SELF_MIN(SELF_MIN), .REF_INTERVAL(REF_INTERVAL), .WARM_CYCLES(WARM_CYCLES),
    .PEND_MAX(PEND_MAX)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phaseDone(phaseDone),
    .pendAny(pendAny), .pendFull(pendFull), .warmLast(warmLast)
  );

endmodule

// File: tb/dramRefreshSeq_test.sv
`timescale 1ns/1ps
module dramRefreshSeq_test;

  localparam int INIT_PAUSE = 40, T_CSR = 2, T_RASW = 5, T_RP = 4, T_RPS = 6;
  localparam int SELF_MIN = 30, REF_INTERVAL = 200, WARM = 8, PEND_MAX = 8;

  logic clk = 1'b0, rstN = 1'b0, ctlGnt = 1'b0, ctlIdle = 1'b0, sleepReq = 1'b0;
  logic refReq, seqOwn, initDone, sleepAck, rasN, weN;
  logic [1:0] casN;

  always #4 clk = ~clk;

  dramRefreshSeq #(
    .INIT_PAUSE(INIT_PAUSE), .T_CSR(T_CSR), .T_RASW(T_RASW), .T_RP(T_RP), .T_RPS(T_RPS),
    .SELF_MIN(SELF_MIN), .REF_INTERVAL(REF_INTERVAL), .WARM_CYCLES(WARM),
    .PEND_MAX(PEND_MAX), .CAS_LANES(2'b11)
  ) uut (
    .clk(clk), .rstN(rstN), .ctlGnt(ctlGnt), .ctlIdle(ctlIdle), .sleepReq(sleepReq),
    .refReq(refReq), .seqOwn(seqOwn), .initDone(initDone), .sleepAck(sleepAck),
    .rasN(rasN), .casN(casN), .weN(weN)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Pin monitor, sampling at the falling clock edge.
  int cyc = 0, rasFalls = 0, lastFallCyc = 0, prevFallCyc = 0;
  int orderViol = 0, casViol = 0, weViol = 0, ackViol = 0, preViol = 0, widthViol = 0;
  int lowRun = 0, rasHighRun = 0, preRun = 0, epN = 0;
  int epLow [4];
  int epGap [4];
  bit epOn = 1'b0, pulseAck = 1'b0;
  logic prevRas = 1'b1, prevOwn = 1'b1;
  logic [1:0] prevCas = 2'b11;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (!rasN && prevRas) begin
        rasFalls++; prevFallCyc = lastFallCyc; lastFallCyc = cyc;
        if (prevCas == 2'b11 || casN == 2'b11) orderViol++;
        if (epOn && epN < 4) epGap[epN] = rasHighRun;
      end
      if (!rasN && casN != 2'b00) casViol++;
      if (seqOwn && !weN) weViol++;
      if (sleepAck && rasN) ackViol++;
      if (prevOwn && !seqOwn && preRun < T_RP) preViol++;
      if (rasN && !prevRas) begin
        if (epOn && epN < 4) begin epLow[epN] = lowRun; epN++; end
        if (!pulseAck && lowRun != T_RASW) widthViol++;
      end
      if (!rasN) begin
        lowRun = prevRas ? 1 : lowRun + 1;
        pulseAck = prevRas ? sleepAck : (pulseAck | sleepAck);
        rasHighRun = 0;
      end else rasHighRun++;
      if (seqOwn && rasN && casN == 2'b11) preRun++; else preRun = 0;
      prevRas = rasN; prevCas = casN; prevOwn = seqOwn;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  // Wait until the bus is released after the next refresh starts, so the timer has just ticked.
  task automatic syncToTick();
    int f0 = rasFalls;
    ctlGnt = 1'b1;
    for (int i = 0; i < 3 * REF_INTERVAL && rasFalls == f0; i++) step();
    for (int i = 0; i < 100 && seqOwn; i++) step();
  endtask

  function automatic bit inRange(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic sleepEpisode(input int extraHold, output bit ok);
    int t = 0;
    epN = 0; epOn = 1'b1; sleepReq = 1'b1; ctlGnt = 1'b1;
    while (!sleepAck && t < 500) begin step(); t++; end
    step(extraHold);
    sleepReq = 1'b0;
    t = 0;
    while (seqOwn && t < 2000) begin step(); t++; end
    epOn = 1'b0;
    ok = (t < 2000);
  endtask

  initial begin
    int n, f0, f1;
    bit ok;
    void'($urandom(32'd2718));
    step(3);
    // R1 reset state
    check(rasN === 1'b1 && casN === 2'b11 && seqOwn === 1'b1, "R1 reset strobes/own",
          {rasN, casN, seqOwn}, 4'b1111);
    check(initDone === 1'b0 && refReq === 1'b0, "R1 reset flags", {initDone, refReq}, 0);
    rstN = 1'b1;
    n = 0;
    while (casN == 2'b11 && n < 1000) begin n++; step(); end
    check(n == INIT_PAUSE, "R1 power-up pause length", n, INIT_PAUSE);
    n = 0;
    while (!initDone && n < 1000) begin
      if (refReq) check(1'b0, "R1 refReq before init", 1, 0);
      n++; step();
    end
    check(rasFalls == WARM, "R1 warm-up refresh count", rasFalls, WARM);
    step(2);
    check(!seqOwn && initDone, "R1 released after warm-up", seqOwn, 0);

    // R2 periodic rate under continuous grant
    ctlGnt = 1'b1;
    f0 = rasFalls;
    while (rasFalls < f0 + 2 && n < 5000) begin n++; step(); end
    check(lastFallCyc - prevFallCyc == REF_INTERVAL, "R2 refresh spacing",
          lastFallCyc - prevFallCyc, REF_INTERVAL);
    f0 = rasFalls;
    while (rasFalls < f0 + 1) step();
    check(lastFallCyc - prevFallCyc == REF_INTERVAL, "R2 refresh spacing again",
          lastFallCyc - prevFallCyc, REF_INTERVAL);

    // R8 postponement, saturation, forced refresh
    syncToTick();
    ctlGnt = 1'b0; ctlIdle = 1'b0;
    f0 = rasFalls;
    step(12 * REF_INTERVAL);
    check(rasFalls == f0, "R8 no refresh without grant or idle", rasFalls - f0, 0);
    check(refReq == 1'b1, "R10 refReq while owed", refReq, 1);
    f0 = rasFalls;
    ctlIdle = 1'b1;
    step(20);
    check(inRange(rasFalls - f0, 1, 2), "R8 forced refresh on idle when full", rasFalls - f0, 1);
    ctlIdle = 1'b0; ctlGnt = 1'b1;
    n = 0;
    while ((refReq || seqOwn) && n < 1000) begin n++; step(); end
    check(inRange(rasFalls - f0, PEND_MAX, PEND_MAX + 1), "R8 saturated backlog drained",
          rasFalls - f0, PEND_MAX);
    check(refReq == 1'b0, "R10 refReq clear after drain", refReq, 0);

    // R6/R7 self-refresh with a long request
    syncToTick();
    sleepEpisode(100, ok);
    check(ok && epN == 3, "R7 pulses in self-refresh ownership", epN, 3);
    check(epLow[0] == T_RASW, "R7 refresh before entry", epLow[0], T_RASW);
    check(epGap[1] == T_RP + T_CSR, "R7 entry right after refresh", epGap[1], T_RP + T_CSR);
    check(epLow[1] >= 100 && epLow[1] >= SELF_MIN, "R6 long self-refresh low time", epLow[1], 100);
    check(epGap[2] == T_RPS + T_CSR, "R6 self-refresh precharge", epGap[2], T_RPS + T_CSR);
    check(epLow[2] == T_RASW, "R7 refresh after exit", epLow[2], T_RASW);

    // R6 early release still honours the minimum
    sleepEpisode(0, ok);
    check(ok && epN == 3, "R7 pulses in short episode", epN, 3);
    check(epLow[1] == SELF_MIN, "R6 minimum self-refresh low time", epLow[1], SELF_MIN);
    check(epGap[2] == T_RPS + T_CSR, "R6 precharge after short episode", epGap[2], T_RPS + T_CSR);

    // R10 random grant/idle phase, then drain
    syncToTick();
    f0 = rasFalls;
    for (int i = 0; i < 20 * REF_INTERVAL; i++) begin
      ctlGnt  = ($urandom % 4) == 0;
      ctlIdle = ($urandom % 2) == 0;
      step();
    end
    ctlGnt = 1'b1; ctlIdle = 1'b0;
    n = 0;
    while ((refReq || seqOwn) && n < 1000) begin n++; step(); end
    f1 = rasFalls - f0;
    check(inRange(f1, 19, 22), "R10 no refresh lost under random grants", f1, 20);

    check(orderViol == 0, "R3 CAS before RAS ordering", orderViol, 0);
    check(widthViol == 0, "R3 RAS low width", widthViol, 0);
    check(weViol == 0, "R4 WE high while owned", weViol, 0);
    check(casViol == 0, "R5 both CAS lanes low during RAS low", casViol, 0);
    check(ackViol == 0, "R5 sleepAck only with RAS low", ackViol, 0);
    check(preViol == 0, "R9 precharge before release", preViol, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule